// File: doc/BRIEF.md
# Multiplexed-Address Flash Command Front End

This block sits between a host bus and a byte-wide flash array whose address pins are shared between two halves of the address. A row/column select strobe marks which half is on the pins. The falling edge of the strobe captures the low half and the rising edge captures the high half, which together form a 21-bit address. Command bytes arrive on a write strobe. Program and erase requests are checked against block protection and against the state of the supplies before they start. A status byte can be read back through an output enable.

A parameterised cycle counter stands in for the program/erase controller, so that the busy phase has a definite length. Busy can be suspended and resumed. All strobes and supply conditions are sampled on the rising edge of `clk`. An edge on a strobe is seen when two consecutive samples differ. Commands are single bytes: 0x40 byte program, 0x20 block erase, 0x30 fast four-byte program, 0xB0 suspend, 0xD0 resume, 0x50 clear status, 0x70 read status, 0xFF read array.

The controller has four states, and they are named here so that the requirements can refer to them:

- ST_IDLE: ready for any command.
- ST_BUSY: an operation is counting down.
- ST_SUSP: the operation is suspended and its count is frozen.
- ST_OFF: the main supply is invalid.

The transitions are:

- ST_IDLE to ST_BUSY: start.
- ST_BUSY to ST_IDLE: done.
- ST_BUSY to ST_SUSP: suspend.
- ST_SUSP to ST_BUSY: resume.
- Any state to ST_OFF: supply loss.
- ST_OFF to ST_IDLE: supply return.

Top module: `flash_cmd_fe`

## Requirements
- R1: The first clock edge that samples `rc_sel` low after it was high loads `addr_in[10:0]` into `cur_addr[10:0]`.
- R2: The first clock edge that samples `rc_sel` high after it was low loads `addr_in[9:0]` into `cur_addr[20:11]`.
- R3: A command byte is taken from `data_in` on the first edge that samples `wr_n` high after it was low, and it acts on that same edge. The command codes are those listed above.
- R4: An accepted 0x40 or 0x30 holds `ready` low for exactly PROG_CYC cycles. An accepted 0x20 holds it low for exactly ERASE_CYC cycles.
- R5: In ST_BUSY every command other than 0xB0 is ignored. This includes program, erase and clear status.
- R6: 0xB0 in ST_BUSY enters ST_SUSP. In that state `ready` is high, status bit 6 is set, and the remaining count is frozen. 0xD0 resumes the operation with the remaining count. Program and erase commands are ignored in ST_SUSP.
- R7: The block number is `cur_addr[20:16]`. Block 31 is protected exactly when `lock_bits[31]` is set, whatever `wp_rel` is. Any other block is protected when `wp_rel` is low, and follows `lock_bits[block]` when `wp_rel` is high. A program or erase to a protected block does not start and sets status bit 5.
- R8: With `vpp_lock` high, a program or erase does not start and sets status bit 3. This check takes priority over the protection check.
- R9: 0x30 with `vpp_high` low does not start and sets status bit 3.
- R10: While `vcc_ok` is low, the block holds ST_OFF with `ready` low, aborts any operation and ignores commands. The first edge with `vcc_ok` high again enters ST_IDLE in read-array mode.
- R11: While `oe_n` is low, `data_drive` is 1. `data_out` then shows the status byte in status mode or 0xFF in read-array mode. While `oe_n` is high, `data_out` is 0x00 and `data_drive` is 0. The status byte has bit 7 = ready, bit 6 = suspended, bit 5 = protection error, bit 3 = supply error and all other bits 0. 0x70 and every accepted or refused program/erase select status mode, 0xFF selects read-array mode, and reset leaves read-array mode with the status byte at 0x80.
- R12: 0x50 in ST_IDLE or ST_SUSP clears status bits 5 and 3. Both bits are sticky until then.
- R13: `status_err` equals status bit 5 OR status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rc_sel | input | 1 | Row/column select strobe |
| addr_in | input | 11 | Shared address pins |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| data_in | input | 8 | Command byte |
| data_out | output | 8 | Read data |
| data_drive | output | 1 | Read data is being driven |
| wp_rel | input | 1 | High: non-top blocks follow their lock bits |
| lock_bits | input | 32 | Per-block lock bits |
| vcc_ok | input | 1 | Main supply above lockout |
| vpp_lock | input | 1 | Programming supply below lockout |
| vpp_high | input | 1 | Programming supply at high level |
| ready | output | 1 | Ready (high) / busy (low) |
| status_err | output | 1 | Any sticky error bit set |
| cur_addr | output | 21 | Assembled address |

## Verification
The assertions check these properties on every cycle:

- The address halves load on the correct strobe edge.
- The counter does not move outside the busy state.
- Commands sent during busy leave the error bits alone.
- A refused start on a locked top block or a locked supply leaves the block idle with the error flag set.
- Losing the main supply drops `ready`.

Other behaviour only the bench's scenarios can show. This covers the exact busy length and the way it adds up across a suspend and resume. It also covers the priority of the supply check over the protection check, return to read-array mode after a supply dip, and the status byte seen through the output enable.

// File: rtl/flashfe_pkg.sv
package flashfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_SUSP = 2'd2,
        ST_OFF  = 2'd3
    } fe_state_e;

    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_FAST   = 8'h30;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'hD0;
    localparam logic [7:0] CMD_CLR    = 8'h50;
    localparam logic [7:0] CMD_RDSR   = 8'h70;
    localparam logic [7:0] CMD_RDARR  = 8'hFF;

    localparam logic [7:0] ARRAY_FILL = 8'hFF;

endpackage

// File: rtl/flashfe_addr_capture.sv
module flashfe_addr_capture #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rc_sel,
    input  logic [ROW_W-1:0]       addr_in,
    output logic [ROW_W+COL_W-1:0] addr_q
);
    logic             rc_prev_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_prev_q <= 1'b1;
            row_q     <= '0;
            col_q     <= '0;
        end else begin
            rc_prev_q <= rc_sel;
            if (rc_prev_q && !rc_sel) row_q <= addr_in;
            if (!rc_prev_q && rc_sel) col_q <= addr_in[COL_W-1:0];
        end
    end

    assign addr_q = {col_q, row_q};

    AST_ROW_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_prev_q && !rc_sel) |=> (addr_q[ROW_W-1:0] == $past(addr_in))); // R1
    AST_COL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rc_prev_q && rc_sel) |=> (addr_q[ROW_W+COL_W-1:ROW_W] == $past(addr_in[COL_W-1:0]))); // R2
endmodule

// File: rtl/flashfe_prot_gate.sv
module flashfe_prot_gate #(
    parameter int BLK_W = 5,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [NBLK-1:0]  lock_bits,
    input  logic             wp_rel,
    output logic             protected_o
);
    localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(NBLK - 1);

    always_comb begin
        if (blk == TOP_BLK) protected_o = lock_bits[NBLK-1];
        else if (!wp_rel)   protected_o = 1'b1;
        else                protected_o = lock_bits[blk];
    end
endmodule

// File: rtl/flashfe_pe_timer.sv
module flashfe_pe_timer #(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    input  logic run,
    output logic done
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= long_sel ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
        else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == CNT_W'(1));

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/flash_cmd_fe.sv
module flash_cmd_fe
    import flashfe_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int BLK_W     = 5,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rc_sel,
    input  logic [ROW_W-1:0]          addr_in,
    input  logic                      wr_n,
    input  logic                      oe_n,
    input  logic [7:0]                data_in,
    output logic [7:0]                data_out,
    output logic                      data_drive,
    input  logic                      wp_rel,
    input  logic [(1<<BLK_W)-1:0]     lock_bits,
    input  logic                      vcc_ok,
    input  logic                      vpp_lock,
    input  logic                      vpp_high,
    output logic                      ready,
    output logic                      status_err,
    output logic [ROW_W+COL_W-1:0]    cur_addr
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int NBLK   = 1 << BLK_W;

    fe_state_e  state_q, state_d;
    logic       wr_prev_q;
    logic       cmd_stb;
    logic       prot_err_q, sup_err_q, smode_q;
    logic       prot_err_d, sup_err_d, smode_d;
    logic       is_pe, supply_bad, blk_prot;
    logic       start, done, run;
    logic [BLK_W-1:0] blk;
    logic [7:0] status_byte;

    flashfe_addr_capture #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .rc_sel(rc_sel), .addr_in(addr_in), .addr_q(cur_addr)
    );

    assign blk = cur_addr[ADDR_W-1 -: BLK_W];

    flashfe_prot_gate #(.BLK_W(BLK_W)) u_prot (
        .blk(blk), .lock_bits(lock_bits), .wp_rel(wp_rel), .protected_o(blk_prot)
    );

    flashfe_pe_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start), .long_sel(data_in == CMD_ERASE),
        .run(run), .done(done)
    );

    assign cmd_stb    = !wr_prev_q && wr_n && vcc_ok;
    assign is_pe      = (data_in == CMD_PROG) || (data_in == CMD_ERASE) || (data_in == CMD_FAST);
    assign supply_bad = vpp_lock || ((data_in == CMD_FAST) && !vpp_high);
    assign start      = (state_q == ST_IDLE) && cmd_stb && is_pe && !supply_bad && !blk_prot;
    assign run        = (state_q == ST_BUSY);

    // next state and flag updates
    always_comb begin
        state_d    = state_q;
        prot_err_d = prot_err_q;
        sup_err_d  = sup_err_q;
        smode_d    = smode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_stb) begin
                    if (is_pe) begin
                        smode_d = 1'b1;
                        if (supply_bad)    sup_err_d  = 1'b1;
                        else if (blk_prot) prot_err_d = 1'b1;
                        else               state_d    = ST_BUSY;
                    end else if (data_in == CMD_CLR) begin
                        prot_err_d = 1'b0;
                        sup_err_d  = 1'b0;
                    end else if (data_in == CMD_RDSR) begin
                        smode_d = 1'b1;
                    end else if (data_in == CMD_RDARR) begin
                        smode_d = 1'b0;
                    end
                end
            end
            ST_BUSY: begin
                if (done)                                state_d = ST_IDLE;
                else if (cmd_stb && data_in == CMD_SUSP) state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (cmd_stb) begin
                    if (data_in == CMD_RESUME) begin
                        state_d = ST_BUSY;
                    end else if (data_in == CMD_CLR) begin
                        prot_err_d = 1'b0;
                        sup_err_d  = 1'b0;
                    end else if (data_in == CMD_RDSR) begin
                        smode_d = 1'b1;
                    end else if (data_in == CMD_RDARR) begin
                        smode_d = 1'b0;
                    end
                end
            end
            ST_OFF: begin
                state_d = ST_IDLE;
                smode_d = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!vcc_ok) begin
            state_d = ST_OFF;
            smode_d = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            wr_prev_q  <= 1'b1;
            prot_err_q <= 1'b0;
            sup_err_q  <= 1'b0;
            smode_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            wr_prev_q  <= wr_n;
            prot_err_q <= prot_err_d;
            sup_err_q  <= sup_err_d;
            smode_q    <= smode_d;
        end
    end

    // outputs
    always_comb begin
        ready       = (state_q == ST_IDLE) || (state_q == ST_SUSP);
        status_byte = {ready, (state_q == ST_SUSP), prot_err_q, 1'b0, sup_err_q, 3'b000};
        status_err  = prot_err_q || sup_err_q;
        data_drive  = !oe_n;
        if (oe_n)         data_out = 8'h00;
        else if (smode_q) data_out = status_byte;
        else              data_out = ARRAY_FILL;
    end

    AST_LOCKOUT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> !ready); // R10
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cmd_stb && data_in != CMD_SUSP)
        |=> ($stable(prot_err_q) && $stable(sup_err_q) && state_q != ST_SUSP)); // R5
    AST_SUPPLY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_stb && vpp_lock &&
         (data_in == CMD_PROG || data_in == CMD_ERASE || data_in == CMD_FAST))
        |=> (ready && status_err && state_q == ST_IDLE)); // R8
    AST_TOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_stb && !vpp_lock && data_in == CMD_PROG &&
         cur_addr[ADDR_W-1 -: BLK_W] == '1 && lock_bits[NBLK-1])
        |=> (ready && status_err && state_q == ST_IDLE)); // R7
endmodule

// File: tb/flash_cmd_fe_tb_top.sv
module flash_cmd_fe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N     = 8;
    localparam int ERASE_N    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_sel = 1'b1;
    logic [10:0] addr_in = '0;
    logic        wr_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [7:0]  data_out;
    logic        data_drive;
    logic        wp_rel = 1'b1;
    logic [31:0] lock_bits = '0;
    logic        vcc_ok = 1'b1;
    logic        vpp_lock = 1'b0;
    logic        vpp_high = 1'b0;
    logic        ready;
    logic        status_err;
    logic [20:0] cur_addr;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    bit live = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_fe #(.PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .rc_sel(rc_sel), .addr_in(addr_in), .wr_n(wr_n),
        .oe_n(oe_n), .data_in(data_in), .data_out(data_out), .data_drive(data_drive),
        .wp_rel(wp_rel), .lock_bits(lock_bits), .vcc_ok(vcc_ok), .vpp_lock(vpp_lock),
        .vpp_high(vpp_high), .ready(ready), .status_err(status_err), .cur_addr(cur_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 busy, 2 suspended, 3 off
    int       m_state = 0, m_left = 0;
    bit [10:0] m_row = '0;
    bit [9:0]  m_col = '0;
    bit m_perr = 0, m_serr = 0, m_smode = 0, m_rc_prev = 1, m_wr_prev = 1;

    function automatic bit m_blocked(input bit [4:0] b);
        if (b == 5'd31) return lock_bits[31];
        if (!wp_rel) return 1'b1;
        return lock_bits[b];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_row = '0; m_col = '0;
            m_perr = 0; m_serr = 0; m_smode = 0; m_rc_prev = 1; m_wr_prev = 1;
        end else begin
            bit stb, pe;
            stb = !m_wr_prev && wr_n && vcc_ok;
            pe  = (data_in == 8'h40) || (data_in == 8'h20) || (data_in == 8'h30);
            if (!vcc_ok) begin
                m_state = 3; m_smode = 0;
            end else if (m_state == 0) begin
                if (stb && pe) begin
                    m_smode = 1;
                    if (vpp_lock || (data_in == 8'h30 && !vpp_high)) m_serr = 1;
                    else if (m_blocked(m_col[9:5])) m_perr = 1;
                    else begin m_state = 1; m_left = (data_in == 8'h20) ? ERASE_N : PROG_N; end
                end else if (stb && data_in == 8'h50) begin m_perr = 0; m_serr = 0; end
                else if (stb && data_in == 8'h70) m_smode = 1;
                else if (stb && data_in == 8'hFF) m_smode = 0;
            end else if (m_state == 1) begin
                m_left--;
                if (m_left == 0) m_state = 0;
                else if (stb && data_in == 8'hB0) m_state = 2;
            end else if (m_state == 2) begin
                if (stb && data_in == 8'hD0) m_state = 1;
                else if (stb && data_in == 8'h50) begin m_perr = 0; m_serr = 0; end
                else if (stb && data_in == 8'h70) m_smode = 1;
                else if (stb && data_in == 8'hFF) m_smode = 0;
            end else begin
                m_state = 0; m_smode = 0;
            end
            if (m_rc_prev && !rc_sel) m_row = addr_in;
            if (!m_rc_prev && rc_sel) m_col = addr_in[9:0];
            m_rc_prev = rc_sel;
            m_wr_prev = wr_n;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            bit m_ready;
            bit [7:0] m_stat, m_data;
            m_ready = (m_state == 0) || (m_state == 2);
            m_stat  = {m_ready, m_state == 2, m_perr, 1'b0, m_serr, 3'b000};
            m_data  = oe_n ? 8'h00 : (m_smode ? m_stat : 8'hFF);
            chk("R1 R2 model address", cur_addr, {m_col, m_row});
            chk("R4 model ready", ready, m_ready);
            chk("R13 model status_err", status_err, m_perr | m_serr);
            chk("R11 model data_out", data_out, m_data);
            if (!ready && vcc_ok) busy_cnt++;
        end
    end

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic set_addr(input bit [10:0] row, input bit [9:0] col);
        rc_sel = 1'b0; addr_in = row; step();
        rc_sel = 1'b1; addr_in = {1'b0, col}; step();
    endtask

    task automatic wcmd(input bit [7:0] b);
        data_in = b; wr_n = 1'b0; step();
        wr_n = 1'b1; step();
    endtask

    task automatic rd(input string tag, input int exp);
        oe_n = 1'b0; #1;
        chk(tag, data_out, exp);
        chk(tag, data_drive, 1);
        oe_n = 1'b1; #1;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2000 && !ready; g++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1; live = 1; step();
        chk("R11 reset ready", ready, 1);
        chk("R11 reset drive off", data_drive, 0);
        chk("R11 reset data idle", data_out, 8'h00);
        rd("R11 reset array read", 8'hFF);
        wcmd(8'h70);
        rd("R11 reset status", 8'h80);

        // R1 R2: address assembly across both strobe edges
        set_addr(11'h5A5, 10'h063);
        chk("R1 row half", cur_addr[10:0], 11'h5A5);
        chk("R2 column half", cur_addr[20:11], 10'h063);
        rc_sel = 1'b0; addr_in = 11'h123; step();
        chk("R1 row reload keeps column", cur_addr, {10'h063, 11'h123});

        // R4 R3 program length, block 3 unlocked
        busy_cnt = 0; wcmd(8'h40);
        chk("R3 R4 program accepted", ready, 0);
        wait_idle();
        chk("R4 program busy length", busy_cnt, PROG_N);

        // R8 supply lock, then R5 commands ignored while busy
        vpp_lock = 1'b1; wcmd(8'h40);
        chk("R8 supply lock refuses", ready, 1);
        rd("R8 supply error bit", 8'h88);
        chk("R13 status_err on supply", status_err, 1);
        vpp_lock = 1'b0; busy_cnt = 0; wcmd(8'h40);
        wcmd(8'h50); wcmd(8'h20); wcmd(8'hFF);
        chk("R5 still busy", ready, 0);
        rd("R5 status during busy", 8'h08);
        wait_idle();
        chk("R5 busy length unchanged", busy_cnt, PROG_N);
        rd("R5 sticky error kept", 8'h88);
        wcmd(8'h50);
        rd("R12 clear status", 8'h80);
        chk("R12 status_err cleared", status_err, 0);

        // R6 suspend/resume of erase
        busy_cnt = 0; wcmd(8'h20);
        repeat (5) step();
        wcmd(8'hB0);
        chk("R6 suspended ready", ready, 1);
        rd("R6 suspended status", 8'hC0);
        wcmd(8'h40);
        repeat (20) step();
        rd("R6 program ignored in suspend", 8'hC0);
        wcmd(8'hD0);
        chk("R6 resumed busy", ready, 0);
        wait_idle();
        chk("R6 erase total length", busy_cnt, ERASE_N);

        // R7 top block governed by lock bit only
        set_addr(11'h000, 10'h3E0);
        wp_rel = 1'b0; lock_bits = '0; busy_cnt = 0;
        wcmd(8'h40);
        chk("R7 top block open with wp low", ready, 0);
        wait_idle();
        chk("R7 top block program length", busy_cnt, PROG_N);
        lock_bits[31] = 1'b1; wp_rel = 1'b1;
        wcmd(8'h20);
        rd("R7 locked top block", 8'hA0);
        wcmd(8'h50);
        wp_rel = 1'b0;
        wcmd(8'h40);
        rd("R7 locked top block wp low", 8'hA0);
        wcmd(8'h50);
        set_addr(11'h000, 10'h060);
        wcmd(8'h40);
        chk("R7 wp low protects block 3", ready, 1);
        rd("R7 protection error", 8'hA0);
        wp_rel = 1'b1; lock_bits[3] = 1'b1; wcmd(8'h50);
        vpp_lock = 1'b1; wcmd(8'h40);
        rd("R8 supply outranks protection", 8'h88);
        vpp_lock = 1'b0; lock_bits = '0; wcmd(8'h50);

        // R9 fast program needs high supply
        wcmd(8'h30);
        rd("R9 fast without high supply", 8'h88);
        wcmd(8'h50);
        vpp_high = 1'b1; busy_cnt = 0;
        wcmd(8'h30);
        chk("R9 fast accepted", ready, 0);
        wait_idle();
        chk("R9 R4 fast program length", busy_cnt, PROG_N);
        vpp_high = 1'b0;

        // R10 main supply loss aborts erase
        wcmd(8'h20);
        repeat (4) step();
        vcc_ok = 1'b0; step();
        chk("R10 ready low on supply loss", ready, 0);
        wcmd(8'h70);
        vcc_ok = 1'b1; step();
        chk("R10 back to idle", ready, 1);
        rd("R10 read array mode after return", 8'hFF);
        repeat (10) step();
        chk("R10 aborted erase stays idle", ready, 1);
        chk("R10 no error from ignored write", status_err, 0);

        repeat (3) step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule